// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block is the programming-side front end of a small on-chip code store. A device programmer presents an address split across two pin groups, a data byte, a four-pin operation select, an active-low program strobe and a high-voltage flag. The block decodes the selected operation and holds the byte array. It runs timed byte programming, lock-bit programming and whole-array erase, and returns read data for verify and identification reads.

Every change to the array is timed by the block. After the strobe returns high the ready line drops and stays low for a fixed number of clock cycles. A programmer can wait on that line. It can also poll the byte being written, whose top bit reads inverted until the write completes. Erase needs a strobe held low for a minimum number of cycles. It then sweeps the array one byte per cycle, setting every byte to all ones. The cycle counts are parameters, so short values can be used for simulation.

Top module: `flash_prog_ctrl`

## Requirements
- R1: While reset is asserted and after its release, `ready` is 1 and `dout` is 00h until a read mode is selected. All three lock bits are cleared by reset.
- R2: The 12-bit address is `{addr_hi, addr_lo}`, with `addr_lo` as bits 7:0. The array byte selected is given by the low `ADDR_W` bits of that address.
- R3: With `ctl` = 0111 (byte program) and `hv_en` = 1, the clock edge that first samples `prog_n` high after a low starts a write. From the next cycle `ready` is 0 for exactly `WRITE_CYCLES` cycles.
- R4: A byte write stores the bitwise AND of the old byte and the new data, so bits can only be cleared.
- R5: A read with `ctl` = 0011 taken while a byte write is in progress returns the written data with bit 7 inverted.
- R6: With `ctl` = 0011 and no write in progress, `dout` shows the addressed byte one cycle after the address is applied. If lock bit 1 or lock bit 2 is set, it shows 00h instead.
- R7: With `ctl` = 1000 and `hv_en` = 1, a `prog_n` low pulse of at least `ERASE_PULSE` clock cycles starts an erase when it ends. All lock bits clear at once, and `ready` is 0 for exactly 2^`ADDR_W` cycles. Afterwards every byte reads FFh.
- R8: An erase-mode pulse shorter than `ERASE_PULSE` cycles does nothing: `ready` stays 1 and the lock bits and contents are kept.
- R9: With `ctl` = 1111 and `hv_en` = 1, a pulse sets the lock bits selected by `din[0]`, `din[1]` and `din[2]` (lock bits 1, 2 and 3). `ready` is 0 for `WRITE_CYCLES` cycles. Set lock bits stay set until an erase. Lock bit 3 alone does not block verify.
- R10: With `ctl` = 0000, the full 12-bit addresses 030h, 031h and 032h read 1Eh, 51h, and FFh (`SIG_HV` = 1) or 05h (`SIG_HV` = 0). Every other address reads 00h, and lock bits have no effect.
- R11: A strobe that ends while `ready` is 0 is ignored. It neither changes the array nor lengthens the busy time.
- R12: A program, lock or erase strobe with `hv_en` = 0 is ignored, and `ready` stays 1.
- R13: Any other `ctl` value reads 00h and ignores strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_lo | input | 8 | Address bits 7:0 |
| addr_hi | input | 4 | Address bits 11:8 |
| din | input | 8 | Program data, or lock-bit select in lock mode |
| ctl | input | 4 | Operation select |
| prog_n | input | 1 | Active-low program strobe |
| hv_en | input | 1 | Programming voltage present |
| dout | output | 8 | Registered read data |
| ready | output | 1 | 1 when idle, 0 while a timed operation runs |

## Verification
The hardest cases to reach are the ones where a request is dropped without any visible reaction. These are a strobe arriving mid-write, an erase pulse one cycle too short, and a verify hidden by lock bits. The bench starts each of these from a known array state that it models itself. It then shows the drop through later reads and through the exact count of low `ready` cycles. Polling is checked on every address of an exhaustive write sweep, by reading in the cycle right after each write starts.

// File: rtl/flash_pgm_pkg.sv
package flash_pgm_pkg;

  typedef enum logic [3:0] {
    CTL_SIG   = 4'b0000,
    CTL_READ  = 4'b0011,
    CTL_WRITE = 4'b0111,
    CTL_ERASE = 4'b1000,
    CTL_LOCK  = 4'b1111
  } ctl_e;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_WRITE,
    OP_LOCK,
    OP_ERASE
  } op_e;

  localparam logic [11:0] SIG_BASE = 12'h030;

  // identification byte for a full 12-bit address
  function automatic logic [7:0] sig_byte(input logic [11:0] a, input logic hv);
    logic [7:0] r;
    r = 8'h00;
    if (a == SIG_BASE)              r = 8'h1E;
    else if (a == SIG_BASE + 12'd1) r = 8'h51;
    else if (a == SIG_BASE + 12'd2) r = hv ? 8'hFF : 8'h05;
    return r;
  endfunction

  // value seen on a read while a write is still running
  function automatic logic [7:0] poll_byte(input logic [7:0] d);
    return {~d[7], d[6:0]};
  endfunction

  // programming can only clear bits
  function automatic logic [7:0] program_and(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/fpm_pulse_det.sv
module fpm_pulse_det #(
  parameter int LOW_LIMIT = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  output logic rise,
  output logic long_ok
);
  localparam int CW = $clog2(LOW_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LOW_LIMIT);

  logic          prog_q;
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q  <= 1'b1;
      low_cnt <= '0;
    end else begin
      prog_q <= prog_n;
      if (!prog_n) begin
        if (low_cnt != LIM) low_cnt <= low_cnt + 1'b1;
      end else begin
        low_cnt <= '0;
      end
    end
  end

  assign rise    = prog_n & ~prog_q;
  assign long_ok = (low_cnt == LIM);
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WRITE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              long_ok,
  input  logic              hv_en,
  input  logic [3:0]        ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic              busy,
  output logic              start_evt,
  output logic              ers_start,
  output logic              op_done,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              poll_active,
  output logic              ers_en,
  output logic [ADDR_W-1:0] ers_addr,
  output logic [2:0]        lock_bits
);
  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [TMR_W-1:0]  TMR_LOAD = TMR_W'(WRITE_CYCLES - 1);
  localparam logic [ADDR_W-1:0] LAST_IDX = '1;

  op_e               op_q;
  logic [TMR_W-1:0]  timer;
  logic [ADDR_W-1:0] wa_q, ea_q;
  logic [7:0]        wd_q;
  logic [2:0]        lock_q;
  logic              tmr_zero, lk_commit, ers_last, req_ok;

  assign req_ok    = (ctl == CTL_WRITE) || (ctl == CTL_LOCK) ||
                     ((ctl == CTL_ERASE) && long_ok);
  assign start_evt = rise && (op_q == OP_IDLE) && hv_en && req_ok;
  assign ers_start = start_evt && (ctl == CTL_ERASE);
  assign tmr_zero  = (timer == '0);
  assign wr_en     = (op_q == OP_WRITE) && tmr_zero;
  assign lk_commit = (op_q == OP_LOCK) && tmr_zero;
  assign ers_en    = (op_q == OP_ERASE);
  assign ers_last  = ers_en && (ea_q == LAST_IDX);
  assign op_done   = wr_en | lk_commit | ers_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      timer  <= '0;
      wa_q   <= '0;
      wd_q   <= '0;
      ea_q   <= '0;
      lock_q <= '0;
    end else begin
      if (start_evt) begin
        case (ctl)
          CTL_WRITE: begin
            op_q  <= OP_WRITE;
            timer <= TMR_LOAD;
            wa_q  <= addr;
            wd_q  <= din;
          end
          CTL_LOCK: begin
            op_q  <= OP_LOCK;
            timer <= TMR_LOAD;
            wd_q  <= din;
          end
          default: begin
            op_q   <= OP_ERASE;
            ea_q   <= '0;
            lock_q <= '0;
          end
        endcase
      end else if (op_done) begin
        op_q <= OP_IDLE;
        if (lk_commit) lock_q <= lock_q | wd_q[2:0];
      end else if (op_q != OP_IDLE && op_q != OP_ERASE) begin
        timer <= timer - 1'b1;
      end
      if (ers_en && !ers_last) ea_q <= ea_q + 1'b1;
    end
  end

  assign busy        = (op_q != OP_IDLE);
  assign wr_addr     = wa_q;
  assign wr_data     = wd_q;
  assign poll_active = (op_q == OP_WRITE);
  assign ers_addr    = ea_q;
  assign lock_bits   = lock_q;
endmodule

// File: rtl/fpm_array.sv
module fpm_array
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              ers_en,
  input  logic [ADDR_W-1:0] ers_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)  mem[wr_addr]  <= program_and(mem[wr_addr], wr_data);
    if (ers_en) mem[ers_addr] <= 8'hFF;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_pgm_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int WRITE_CYCLES = 64,
  parameter int ERASE_PULSE  = 128,
  parameter bit SIG_HV       = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr_lo,
  input  logic [3:0] addr_hi,
  input  logic [7:0] din,
  input  logic [3:0] ctl,
  input  logic       prog_n,
  input  logic       hv_en,
  output logic [7:0] dout,
  output logic       ready
);
  logic [11:0]       full_addr;
  logic [ADDR_W-1:0] idx;
  logic              rise, long_ok;
  logic              busy, start_evt, ers_start, op_done;
  logic              wr_en, ers_en, poll_active;
  logic [ADDR_W-1:0] wr_addr, ers_addr;
  logic [7:0]        wr_data, rd_data, dout_d, dout_q;
  logic [2:0]        lock_bits;

  assign full_addr = {addr_hi, addr_lo};
  assign idx       = full_addr[ADDR_W-1:0];

  fpm_pulse_det #(.LOW_LIMIT(ERASE_PULSE)) u_pdet (
    .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .rise(rise), .long_ok(long_ok)
  );

  fpm_seq #(.ADDR_W(ADDR_W), .WRITE_CYCLES(WRITE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .rise(rise), .long_ok(long_ok), .hv_en(hv_en),
    .ctl(ctl), .addr(idx), .din(din), .busy(busy), .start_evt(start_evt),
    .ers_start(ers_start), .op_done(op_done), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .poll_active(poll_active), .ers_en(ers_en),
    .ers_addr(ers_addr), .lock_bits(lock_bits)
  );

  fpm_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ers_en(ers_en), .ers_addr(ers_addr), .rd_addr(idx), .rd_data(rd_data)
  );

  always_comb begin
    case (ctl)
      CTL_READ: begin
        if (poll_active)          dout_d = poll_byte(wr_data);
        else if (|lock_bits[1:0]) dout_d = 8'h00;
        else                      dout_d = rd_data;
      end
      CTL_SIG: dout_d = sig_byte(full_addr, SIG_HV);
      default: dout_d = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= 8'h00;
    else        dout_q <= dout_d;
  end

  assign dout  = dout_q;
  assign ready = ~busy;
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       start_evt,
  input logic       op_done,
  input logic       ers_start,
  input logic [2:0] lock_q
);
  // R3: accepted start drops ready on the next cycle
  a_r3_ready_falls: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !ready);

  // R11: busy persists until the sequencer signals completion
  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !op_done) |=> !ready);

  // R3: ready only returns after a completion event
  a_r3_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(op_done));

  // R9: lock bits never clear except by an erase start
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !ers_start |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  // R7: erase start clears every lock bit
  a_r7_erase_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ers_start |=> (lock_q == 3'b000));
endmodule

bind flash_prog_ctrl fpm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .start_evt(start_evt),
  .op_done(op_done), .ers_start(ers_start), .lock_q(lock_bits)
);

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 9;
  localparam int DEP = 1 << AW;
  localparam int WC  = 6;
  localparam int EP  = 5;

  localparam logic [3:0] M_SIG = 4'b0000, M_RD = 4'b0011, M_WR = 4'b0111,
                         M_ER = 4'b1000, M_LK = 4'b1111, M_NOP = 4'b0101;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] addr_lo, din, dout;
  logic [3:0] addr_hi, ctl;
  logic       prog_n, hv_en, ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] model [DEP];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prog_ctrl #(.ADDR_W(AW), .WRITE_CYCLES(WC), .ERASE_PULSE(EP), .SIG_HV(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_lo(addr_lo), .addr_hi(addr_hi), .din(din),
    .ctl(ctl), .prog_n(prog_n), .hv_en(hv_en), .dout(dout), .ready(ready)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) + ((a >> 8) * 90) + 11);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [3:0] c, input logic [11:0] a, input logic [7:0] d,
                       input logic hv, input int low);
    ctl = c; {addr_hi, addr_lo} = a; din = d; hv_en = hv; prog_n = 1'b0;
    repeat (low) @(negedge clk);
    prog_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] c, input logic [11:0] a, output logic [7:0] v);
    ctl = c; {addr_hi, addr_lo} = a;
    @(negedge clk);
    v = dout;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    rst_n = 1'b0; prog_n = 1'b1; hv_en = 1'b0; ctl = M_NOP;
    addr_lo = 8'h00; addr_hi = 4'h0; din = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(ready), 1);
    chk("R1 dout in reset", int'(dout), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 dout after reset", int'(dout), 0);
    chk("R1 ready after reset", int'(ready), 1);

    // R7: full erase, exact busy length, all bytes FFh
    pulse(M_ER, 12'h000, 8'h00, 1'b1, EP);
    busy_len(n);
    chk("R7 erase busy length", n, DEP);
    for (int a = 0; a < DEP; a++) begin
      model[a] = 8'hFF;
      rd(M_RD, 12'(a), v);
      chk("R7 erased byte", int'(v), 8'hFF);
    end

    // R3 busy length on a first write without polling
    pulse(M_WR, 12'h000, pat(0), 1'b1, 1);
    busy_len(n);
    chk("R3 write busy length", n, WC);
    model[0] = pat(0);

    // R2 R5 R3: exhaustive write sweep with a poll read each time
    for (int a = 1; a < DEP; a++) begin
      pulse(M_WR, 12'(a), pat(a), 1'b1, 1);
      rd(M_RD, 12'(a), v);
      chk("R5 poll value", int'(v), int'({~pat(a)[7], pat(a)[6:0]}));
      busy_len(n);
      chk("R3 remaining busy", n, WC - 1);
      model[a] = pat(a);
    end
    for (int a = 0; a < DEP; a++) begin
      rd(M_RD, 12'(a), v);
      chk("R6 R2 verify", int'(v), int'(model[a]));
    end
    // R2: bits above ADDR_W alias
    rd(M_RD, 12'hE05, v);
    chk("R2 upper bits alias", int'(v), int'(model[5]));

    // R4: AND semantics
    for (int k = 0; k < 4; k++) begin
      logic [7:0] d;
      int a;
      a = 7 + k * 61;
      d = 8'(8'hA5 ^ (k * 8'h33));
      pulse(M_WR, 12'(a), d, 1'b1, 1);
      busy_len(n);
      model[a] = model[a] & d;
      rd(M_RD, 12'(a), v);
      chk("R4 and-program", int'(v), int'(model[a]));
    end

    // R11: strobe during busy is ignored and does not extend busy
    pulse(M_WR, 12'd20, 8'hFF, 1'b1, 1);
    pulse(M_WR, 12'd21, 8'h00, 1'b1, 1);
    busy_len(n);
    chk("R11 busy not extended", n, WC - 2);
    rd(M_RD, 12'd21, v);
    chk("R11 ignored write", int'(v), int'(model[21]));

    // R12: no programming voltage
    pulse(M_WR, 12'd22, 8'h00, 1'b0, 1);
    chk("R12 ready stays high", int'(ready), 1);
    rd(M_RD, 12'd22, v);
    chk("R12 byte unchanged", int'(v), int'(model[22]));

    // R13: unused mode
    pulse(M_NOP, 12'd40, 8'h00, 1'b1, 1);
    chk("R13 ready stays high", int'(ready), 1);
    rd(M_NOP, 12'd40, v);
    chk("R13 reads zero", int'(v), 0);
    rd(M_RD, 12'd40, v);
    chk("R13 byte unchanged", int'(v), int'(model[40]));

    // R10: identification bytes, 5 V variant
    rd(M_SIG, 12'h030, v); chk("R10 sig 030", int'(v), 8'h1E);
    rd(M_SIG, 12'h031, v); chk("R10 sig 031", int'(v), 8'h51);
    rd(M_SIG, 12'h032, v); chk("R10 sig 032", int'(v), 8'h05);
    rd(M_SIG, 12'h033, v); chk("R10 sig 033", int'(v), 8'h00);
    rd(M_SIG, 12'h02F, v); chk("R10 sig 02F", int'(v), 8'h00);
    rd(M_SIG, 12'h130, v); chk("R10 sig 130", int'(v), 8'h00);

    // R9: lock bit 3 alone keeps verify open
    pulse(M_LK, 12'h000, 8'h04, 1'b1, 1);
    busy_len(n);
    chk("R9 lock busy length", n, WC);
    rd(M_RD, 12'd7, v);
    chk("R9 lb3 verify open", int'(v), int'(model[7]));
    // R9 R6: lock bit 1 hides verify
    pulse(M_LK, 12'h000, 8'h01, 1'b1, 1);
    busy_len(n);
    rd(M_RD, 12'd7, v);
    chk("R6 R9 locked verify", int'(v), 0);
    rd(M_SIG, 12'h031, v);
    chk("R10 sig while locked", int'(v), 8'h51);

    // R8: erase pulse one cycle short
    pulse(M_ER, 12'h000, 8'h00, 1'b1, EP - 1);
    chk("R8 short erase ready", int'(ready), 1);
    rd(M_RD, 12'd7, v);
    chk("R8 lock kept", int'(v), 0);
    // R12: erase without voltage
    pulse(M_ER, 12'h000, 8'h00, 1'b0, EP + 2);
    chk("R12 erase no hv", int'(ready), 1);

    // R7: erase clears locks and array
    pulse(M_ER, 12'h000, 8'h00, 1'b1, EP + 3);
    busy_len(n);
    chk("R7 erase busy length 2", n, DEP);
    for (int a = 0; a < DEP; a++) begin
      rd(M_RD, 12'(a), v);
      chk("R7 erased after lock", int'(v), 8'hFF);
    end

    done = 1'b1;
    finish_run();
  end
endmodule